// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block is the interrupt and status logic of a serial port that has a transmit FIFO and a receive FIFO. The data path reports both FIFO fill levels in bytes. The block turns those levels into sample counts, using a programmable sample width of one to four bytes. It compares the counts against two programmed thresholds and keeps a five-bit interrupt status register. It drives a single level-sensitive interrupt line and presents a read-only status word with the sample counts and the FIFO flags.

The data path pulses three events into the block: transmit underrun, receive overrun and a spare AC97 event. Each pulse sets a sticky status bit. A read strobe on the status register returns its current value and clears the sticky bits on the following edge. The two threshold bits are not cleared by a read; they keep following the fill levels. In SPI frame format the receive side has no useful fill level, so the receive threshold bit and the full flag are forced on. While the port enable is low, the status register is frozen, apart from the read clear.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the status register reads 5'b01000 (only the TX threshold bit set), irq is 0, both thresholds are 4 and all enables are 0.
- R2: On each clock edge with portEn high, status bit 3 is set when floor(txLevel / bytesPerSample) <= TX threshold, and cleared otherwise. bytesPerSample is sampleBytes + 1 (00 means 1 byte, 11 means 4 bytes).
- R3: On each clock edge with portEn high, status bit 2 is set when the RX sample count >= RX threshold, and cleared otherwise. When fmt is 3'd1 (SPI), bit 2 is set whatever the level.
- R4: A one-cycle pulse on txUnderrunPulse, rxOverrunPulse or ac97Pulse with portEn high sets status bit 1, bit 0 or bit 4 on that edge. The bit then stays set until it is cleared by a read.
- R5: In a cycle where isrRd is high, isrRdata shows the value before the clear. On that edge bits 4, 1 and 0 are cleared, and bits 3 and 2 keep following R2 and R3.
- R6: When a sticky set pulse and isrRd arrive in the same cycle, the bit being pulsed is set after the edge.
- R7: irq is high exactly when the AND of the enable field and the status register is nonzero. The enable bits use the same positions as the status bits.
- R8: statusWord carries the TX sample count in bits 16:12, the RX sample count in bits 8:4, busy in bit 2, TX-not-full (TX count < 16) in bit 1 and RX-full (RX count >= 16) in bit 0. All other bits are 0. It is combinational from the inputs.
- R9: With fmt 3'd1 (SPI), statusWord bit 0 reads 1 and bits 8:4 read 16.
- R10: While portEn is low, the pulses and the level changes leave the status register unchanged.
- R11: A cycle with ctrlWe high loads the TX threshold from ctrlWdata[16:12], the RX threshold from ctrlWdata[11:7] and the enables from ctrlWdata[4:0]. The new values take effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| portEn | input | 1 | Port enable; status evaluation runs only while high |
| fmt | input | 3 | Frame format code; 3'd1 is SPI |
| sampleBytes | input | 2 | Bytes per sample minus one |
| txLevel | input | 7 | Transmit FIFO fill in bytes |
| rxLevel | input | 7 | Receive FIFO fill in bytes |
| busy | input | 1 | Shifter busy, reflected in the status word |
| txUnderrunPulse | input | 1 | Transmit underrun event pulse |
| rxOverrunPulse | input | 1 | Receive overrun event pulse |
| ac97Pulse | input | 1 | Spare AC97 event pulse |
| ctrlWe | input | 1 | Write strobe for the interrupt control register |
| ctrlWdata | input | 17 | Interrupt control write data (thresholds and enables) |
| isrRd | input | 1 | Read strobe for the status register |
| isrRdata | output | 5 | Status register value |
| statusWord | output | 17 | Read-only FIFO status word |
| irq | output | 1 | Level interrupt output |

## Verification
The status register and irq change on the first clock edge after a level, a pulse, a read strobe or a control write is presented. The bench therefore drives each input at a falling edge and checks those outputs at the next falling edge. The status word has no register on its path, so it is checked in the same half cycle, while the inputs are still held. During a read, the pre-clear value is sampled shortly after the strobe rises and before any edge. Its cleared form is checked one edge later.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int FIELD_W = 5;
  localparam int ISR_W   = 5;

  localparam int BIT_AC97  = 4;
  localparam int BIT_TXTHR = 3;
  localparam int BIT_RXTHR = 2;
  localparam int BIT_TXUND = 1;
  localparam int BIT_RXOVR = 0;

  localparam int CTRL_W     = 17;
  localparam int TXTHR_LSB  = 12;
  localparam int RXTHR_LSB  = 7;

  localparam logic [ISR_W-1:0]   STICKY_MASK = 5'b10011;
  localparam logic [ISR_W-1:0]   ISR_RESET   = 5'b01000;
  localparam logic [FIELD_W-1:0] THR_RESET   = 5'd4;

  localparam logic [2:0] FMT_SPI = 3'd1;

  typedef struct packed {
    logic              evalEn;
    logic              clrSticky;
    logic [ISR_W-1:0]  setMask;
  } isrStrobe_t;
endpackage

// File: rtl/fifo_irq_cnt.sv
module fifo_irq_cnt
  import fifo_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = 7,
  parameter int SB_W       = 2
) (
  input  logic [LVL_W-1:0]   level,
  input  logic [SB_W-1:0]    sampleCode,
  output logic [FIELD_W-1:0] samples
);
  localparam logic [LVL_W-1:0]   DEPTH_LVL = LVL_W'(FIFO_DEPTH);
  localparam logic [FIELD_W-1:0] DEPTH_CNT = FIELD_W'(FIFO_DEPTH);

  logic [LVL_W-1:0] divisor;
  logic [LVL_W-1:0] quotient;

  always_comb begin
    divisor  = LVL_W'(sampleCode) + LVL_W'(1);
    quotient = level / divisor;
    samples  = (quotient > DEPTH_LVL) ? DEPTH_CNT : quotient[FIELD_W-1:0];
  end
endmodule

// File: rtl/fifo_irq_dp.sv
module fifo_irq_dp
  import fifo_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = 7,
  parameter int SB_W       = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  isrStrobe_t         strobe,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [SB_W-1:0]    sampleBytes,
  input  logic [2:0]         fmt,
  input  logic               busy,
  input  logic [FIELD_W-1:0] txThr,
  input  logic [FIELD_W-1:0] rxThr,
  output logic [ISR_W-1:0]   isr,
  output logic [CTRL_W-1:0]  statusWord
);
  localparam int NDIR = 2;
  localparam logic [FIELD_W-1:0] DEPTH_CNT = FIELD_W'(FIFO_DEPTH);

  logic [LVL_W-1:0]   levels [NDIR];
  logic [FIELD_W-1:0] cnt    [NDIR];

  assign levels[0] = txLevel;
  assign levels[1] = rxLevel;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    fifo_irq_cnt #(
      .FIFO_DEPTH(FIFO_DEPTH),
      .LVL_W     (LVL_W),
      .SB_W      (SB_W)
    ) u_cnt (
      .level     (levels[d]),
      .sampleCode(sampleBytes),
      .samples   (cnt[d])
    );
  end

  logic               spiMode;
  logic               txHit;
  logic               rxHit;
  logic               txNotFull;
  logic               rxFull;
  logic [FIELD_W-1:0] rxShown;
  logic [ISR_W-1:0]   isrNext;

  always_comb begin
    spiMode   = (fmt == FMT_SPI);
    txHit     = (cnt[0] <= txThr);
    rxHit     = spiMode | (cnt[1] >= rxThr);
    txNotFull = (cnt[0] < DEPTH_CNT);
    rxFull    = spiMode | (cnt[1] >= DEPTH_CNT);
    rxShown   = spiMode ? DEPTH_CNT : cnt[1];
    statusWord = {cnt[0], 3'b000, rxShown, 1'b0, busy, txNotFull, rxFull};
  end

  always_comb begin
    isrNext = isr;
    if (strobe.clrSticky) isrNext = isrNext & ~STICKY_MASK;
    isrNext = isrNext | (strobe.setMask & STICKY_MASK);
    if (strobe.evalEn) begin
      isrNext[BIT_TXTHR] = txHit;
      isrNext[BIT_RXTHR] = rxHit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= ISR_RESET;
    else        isr <= isrNext;
  end
endmodule

// File: rtl/fifo_irq_ctl.sv
module fifo_irq_ctl
  import fifo_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               portEn,
  input  logic               isrRd,
  input  logic               txUnderrunPulse,
  input  logic               rxOverrunPulse,
  input  logic               ac97Pulse,
  input  logic               ctrlWe,
  input  logic [CTRL_W-1:0]  ctrlWdata,
  input  logic [ISR_W-1:0]   isr,
  output isrStrobe_t         strobe,
  output logic [FIELD_W-1:0] txThr,
  output logic [FIELD_W-1:0] rxThr,
  output logic               irq
);
  logic [ISR_W-1:0] ienQ;
  logic [1:0]       unusedCtrlBits;

  assign unusedCtrlBits = ctrlWdata[RXTHR_LSB-1:ISR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txThr <= THR_RESET;
      rxThr <= THR_RESET;
      ienQ  <= '0;
    end else if (ctrlWe) begin
      txThr <= ctrlWdata[TXTHR_LSB +: FIELD_W];
      rxThr <= ctrlWdata[RXTHR_LSB +: FIELD_W];
      ienQ  <= ctrlWdata[ISR_W-1:0];
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.evalEn    = portEn;
    strobe.clrSticky = isrRd;
    strobe.setMask[BIT_TXUND] = portEn & txUnderrunPulse;
    strobe.setMask[BIT_RXOVR] = portEn & rxOverrunPulse;
    strobe.setMask[BIT_AC97]  = portEn & ac97Pulse;
  end

  assign irq = |(ienQ & isr);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int FIFO_DEPTH       = 16,
  parameter int MAX_SAMPLE_BYTES = 4,
  localparam int LVL_W = $clog2(FIFO_DEPTH * MAX_SAMPLE_BYTES + 1),
  localparam int SB_W  = $clog2(MAX_SAMPLE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              portEn,
  input  logic [2:0]        fmt,
  input  logic [SB_W-1:0]   sampleBytes,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              busy,
  input  logic              txUnderrunPulse,
  input  logic              rxOverrunPulse,
  input  logic              ac97Pulse,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              isrRd,
  output logic [ISR_W-1:0]  isrRdata,
  output logic [CTRL_W-1:0] statusWord,
  output logic              irq
);
  isrStrobe_t         strobe;
  logic [FIELD_W-1:0] txThr;
  logic [FIELD_W-1:0] rxThr;
  logic [ISR_W-1:0]   isr;

  fifo_irq_ctl u_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .portEn         (portEn),
    .isrRd          (isrRd),
    .txUnderrunPulse(txUnderrunPulse),
    .rxOverrunPulse (rxOverrunPulse),
    .ac97Pulse      (ac97Pulse),
    .ctrlWe         (ctrlWe),
    .ctrlWdata      (ctrlWdata),
    .isr            (isr),
    .strobe         (strobe),
    .txThr          (txThr),
    .rxThr          (rxThr),
    .irq            (irq)
  );

  fifo_irq_dp #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .LVL_W     (LVL_W),
    .SB_W      (SB_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .sampleBytes(sampleBytes),
    .fmt        (fmt),
    .busy       (busy),
    .txThr      (txThr),
    .rxThr      (rxThr),
    .isr        (isr),
    .statusWord (statusWord)
  );

  assign isrRdata = isr;
endmodule

// File: rtl/fifo_irq_chk.sv
module fifo_irq_chk #(
  parameter int FIFO_DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        portEn,
  input logic [2:0]  fmt,
  input logic        txUnderrunPulse,
  input logic        rxOverrunPulse,
  input logic        isrRd,
  input logic [4:0]  isrRdata,
  input logic [16:0] statusWord,
  input logic        irq
);
  // R4: sticky overrun bit holds without a read
  a_r4_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (isrRdata[0] && !isrRd) |=> isrRdata[0]);

  // R5: read clears underrun unless it is pulsed at the same time
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (isrRd && !(portEn && txUnderrunPulse)) |=> !isrRdata[1]);

  // R6: a set pulse wins over a read clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (portEn && rxOverrunPulse) |=> isrRdata[0]);

  // R7: interrupt only with some status bit set
  a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (isrRdata != 5'd0));

  // R9: SPI status word forces full flag and depth count
  a_r9_spi_status: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 3'd1) |-> (statusWord[0] && statusWord[8:4] == 5'(FIFO_DEPTH)));

  // R10: status frozen while disabled and not read
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!portEn && !isrRd) |=> $stable(isrRdata));
endmodule

bind fifo_irq_ctrl fifo_irq_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (.*);

// File: tb/fifo_irq_ctrl_test.sv
`timescale 1ns/1ps
module fifo_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        portEn = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [1:0]  sampleBytes = 2'd0;
  logic [6:0]  txLevel = '0;
  logic [6:0]  rxLevel = '0;
  logic        busy = 1'b0;
  logic        txUnderrunPulse = 1'b0;
  logic        rxOverrunPulse = 1'b0;
  logic        ac97Pulse = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [16:0] ctrlWdata = '0;
  logic        isrRd = 1'b0;
  logic [4:0]  isrRdata;
  logic [16:0] statusWord;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fifo_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .portEn(portEn), .fmt(fmt),
    .sampleBytes(sampleBytes), .txLevel(txLevel), .rxLevel(rxLevel),
    .busy(busy), .txUnderrunPulse(txUnderrunPulse),
    .rxOverrunPulse(rxOverrunPulse), .ac97Pulse(ac97Pulse),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .isrRd(isrRd),
    .isrRdata(isrRdata), .statusWord(statusWord), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [16:0] expWord(input int tc, input int rc,
                                          input logic bsy, input logic spi);
    int shownRc;
    logic full;
    shownRc = spi ? 16 : rc;
    full = spi ? 1'b1 : (rc >= 16);
    return {5'(tc), 3'b000, 5'(shownRc), 1'b0, bsy, (tc < 16), full};
  endfunction

  task automatic wrCtrl(input int txT, input int rxT, input logic [4:0] ien);
    @(negedge clk);
    ctrlWe = 1'b1;
    ctrlWdata = {5'(txT), 5'(rxT), 2'b00, ien};
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic pulse(input logic u, input logic o, input logic a);
    @(negedge clk);
    txUnderrunPulse = u; rxOverrunPulse = o; ac97Pulse = a;
    @(negedge clk);
    txUnderrunPulse = 1'b0; rxOverrunPulse = 1'b0; ac97Pulse = 1'b0;
  endtask

  task automatic sweep(input string tag, input int txT, input int rxT, input logic spi);
    for (int code = 0; code < 4; code++) begin
      for (int lvl = 0; lvl <= 16 * (code + 1); lvl++) begin
        int rxl, tc, rc;
        logic bsy;
        rxl = 16 * (code + 1) - lvl;
        bsy = lvl[0];
        @(negedge clk);
        sampleBytes = 2'(code);
        txLevel = 7'(lvl);
        rxLevel = 7'(rxl);
        busy = bsy;
        tc = lvl / (code + 1);
        rc = rxl / (code + 1);
        @(negedge clk);
        chk({tag, " R2 tx threshold bit"}, 32'(isrRdata[3]), 32'(tc <= txT));
        chk({tag, " R3 rx threshold bit"}, 32'(isrRdata[2]), 32'(spi || rc >= rxT));
        chk({tag, spi ? " R9 status word" : " R8 status word"},
            32'(statusWord), 32'(expWord(tc, rc, bsy, spi)));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", 32'(isrRdata), 32'h08);
    chk("R1 reset irq", 32'(irq), 32'h0);
    chk("R8 idle status word", 32'(statusWord), 32'(expWord(0, 0, 1'b0, 1'b0)));

    // R10: disabled port ignores levels and pulses
    txLevel = 7'd10;
    rxLevel = 7'd12;
    pulse(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R10 frozen while disabled", 32'(isrRdata), 32'h08);

    // R1: default thresholds of 4
    portEn = 1'b1;
    txLevel = 7'd5; rxLevel = 7'd4;
    @(negedge clk);
    chk("R1 default tx threshold 5>4", 32'(isrRdata[3]), 32'h0);
    chk("R1 default rx threshold 4>=4", 32'(isrRdata[2]), 32'h1);
    txLevel = 7'd4; rxLevel = 7'd3;
    @(negedge clk);
    chk("R1 default tx threshold 4<=4", 32'(isrRdata[3]), 32'h1);
    chk("R1 default rx threshold 3<4", 32'(isrRdata[2]), 32'h0);

    sweep("default", 4, 4, 1'b0);
    wrCtrl(9, 11, 5'b00000);
    sweep("R11 programmed", 9, 11, 1'b0);
    wrCtrl(0, 16, 5'b00000);
    sweep("R11 extreme", 0, 16, 1'b0);
    wrCtrl(9, 11, 5'b00000);

    // R4 / R5 / R6 sticky behaviour
    @(negedge clk);
    sampleBytes = 2'd0; txLevel = 7'd0; rxLevel = 7'd0; busy = 1'b0;
    isrRd = 1'b1;
    @(negedge clk);
    isrRd = 1'b0;
    chk("R5 clear before sticky test", 32'(isrRdata), 32'h08);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R4 underrun set", 32'(isrRdata), 32'h0A);
    pulse(1'b0, 1'b1, 1'b1);
    chk("R4 overrun and ac97 set", 32'(isrRdata), 32'h1B);
    repeat (3) @(negedge clk);
    chk("R4 sticky bits hold", 32'(isrRdata), 32'h1B);
    isrRd = 1'b1;
    #1;
    chk("R5 read shows value before clear", 32'(isrRdata), 32'h1B);
    @(negedge clk);
    isrRd = 1'b0;
    chk("R5 sticky cleared, thresholds kept", 32'(isrRdata), 32'h08);
    pulse(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    isrRd = 1'b1; rxOverrunPulse = 1'b1;
    @(negedge clk);
    isrRd = 1'b0; rxOverrunPulse = 1'b0;
    chk("R6 set wins over read clear", 32'(isrRdata), 32'h09);

    // R7 interrupt masking
    wrCtrl(9, 11, 5'b00010);
    chk("R7 masked bit gives no irq", 32'(irq), 32'h0);
    wrCtrl(9, 11, 5'b01000);
    chk("R7 tx threshold enabled", 32'(irq), 32'h1);
    wrCtrl(9, 11, 5'b00001);
    chk("R7 overrun enabled", 32'(irq), 32'h1);
    @(negedge clk);
    isrRd = 1'b1;
    @(negedge clk);
    isrRd = 1'b0;
    chk("R7 irq drops after read clear", 32'(irq), 32'h0);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R7 irq rises on overrun", 32'(irq), 32'h1);
    wrCtrl(9, 11, 5'b00000);

    // R9 and R3 in SPI format
    fmt = 3'd1;
    sweep("R9 spi", 9, 11, 1'b1);
    fmt = 3'd3;
    sweep("R3 other format", 9, 11, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule